// File: doc/BRIEF.md
# Amplifier Channel Output Mode Sequencer

This block keeps one operating state for each output channel of a multi-channel bridge amplifier and moves every channel between standby, Hi-Z, mute, play and low-low. Its inputs are the control bits held in the register file, the action requests of the fault manager and a ramp-complete strobe from the analog mute ramp. For each channel it drives a 3-bit mode code to the output stage and the Hi-Z, low-low, mute and play status bits that the bus reads back.

Each channel has its own state machine. Its states are `ST_STBY`, `ST_HIZ`, `ST_MUTE`, `ST_PLAY`, `ST_LL`, `ST_RAMP_UP` (mute going to play) and `ST_RAMP_DN` (play going to mute). A combinational stage first resolves the commanded target. The order of precedence is standby request, then Hi-Z request or register reset, then low-low, then run with the mute choice, and otherwise Hi-Z. The transitions are:

- Commanded moves: each state goes straight to the target, except for the two mute/play moves.
- Mute and play: `ST_MUTE` goes to `ST_RAMP_UP` and `ST_PLAY` goes to `ST_RAMP_DN`. Each ramp state completes on the ramp strobe, or goes straight to any other target. A ramp that is reversed returns at once to the state it left.
- Paired channels: in a bridged pair the upper channel loads the next state of the lower channel, so the two can never differ.

Top module: `omc_mode_ctrl`

## Requirements
- R1: After reset every channel is in Hi-Z. The mode codes are standby 0, Hi-Z 1, mute 2, play 3 and low-low 4, with channel c in `stage_mode_o[3c+2:3c]`. At reset the Hi-Z status bits are all 1 and every other status bit is 0.
- R2: While `hiz_to_play_i` is 0 and no other command applies, a channel stays in Hi-Z whatever its mute bit. While `hiz_to_play_i` is 1, a channel in Hi-Z moves in one cycle to mute if its mute bit is 1, or to play if it is 0.
- R3: A move between mute and play changes the mode code on the next cycle. The mute/play status bits keep their old value until the cycle after `ramp_done_i` is sampled high.
- R4: A set low-low bit places the channel in low-low (code 4) and sets its low-low status bit. Low-low takes precedence over the run and mute bits.
- R5: In `stat_hiz_ll_o` the low-low bits sit above the Hi-Z bits, and in `stat_mute_play_o` the mute bits sit above the play bits. Within each half, bit c belongs to channel c.
- R6: Pair bit k joins channels 2k and 2k+1. While it is set, the lower channel's bits decide the state of both channels, the upper channel's own mute and low-low bits have no effect, and both channels hold the same state from the first edge at which the pair bit is sampled set.
- R7: A fault Hi-Z request puts the channel in Hi-Z on the next cycle and holds it there against all register commands. In a pair, a request on either channel acts on both.
- R8: The fault standby request puts every channel in standby (code 0, all status bits 0) on the next cycle. It takes precedence over Hi-Z requests.
- R9: While the register reset bit is set, every channel is held in Hi-Z. Fault requests still take precedence.
- R10: When a fault request drops, the channel takes its commanded state on the next cycle. A fault that arrives during a ramp cancels the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_reset_i | input | 1 | Register reset bit; holds all channels in Hi-Z |
| hiz_to_play_i | input | 1 | Global run bit |
| mute_ctl_i | input | NCH | Per-channel mute choice (1 mute, 0 play) |
| lowlow_ctl_i | input | NCH | Per-channel low-low command |
| pair_ctl_i | input | NCH/2 | Bridged pair enables |
| flt_hiz_i | input | NCH | Fault manager Hi-Z requests |
| flt_stby_i | input | 1 | Fault manager standby request |
| ramp_done_i | input | 1 | Mute ramp complete strobe |
| stage_mode_o | output | 3*NCH | Output-stage mode codes |
| stat_hiz_ll_o | output | 2*NCH | Low-low (upper half) and Hi-Z (lower half) status |
| stat_mute_play_o | output | 2*NCH | Mute (upper half) and play (lower half) status |

## Verification
Two functions can land on the same clock edge: ramp completion and a fault Hi-Z request. The bench first puts channel 0 into a play-to-mute ramp. It then raises `ramp_done_i` and the channel's Hi-Z request together, so that both are sampled at one edge. The expected result is Hi-Z with both mute and play status clear. A design that lets the ramp finish first would instead show mute status. The bench also enables a pair while the two channels sit in different states, and checks that they agree on the very next cycle.

// File: rtl/omc_pkg.sv
package omc_pkg;

    typedef enum logic [2:0] {
        ST_STBY    = 3'd0,
        ST_HIZ     = 3'd1,
        ST_MUTE    = 3'd2,
        ST_PLAY    = 3'd3,
        ST_LL      = 3'd4,
        ST_RAMP_UP = 3'd5,
        ST_RAMP_DN = 3'd6
    } omc_state_e;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_STBY = 3'd0;
    localparam logic [MODE_W-1:0] MODE_HIZ  = 3'd1;
    localparam logic [MODE_W-1:0] MODE_MUTE = 3'd2;
    localparam logic [MODE_W-1:0] MODE_PLAY = 3'd3;
    localparam logic [MODE_W-1:0] MODE_LL   = 3'd4;

    // Output stage follows the ramp target; status follows the settled state.
    function automatic logic [MODE_W-1:0] stage_code(omc_state_e s);
        logic [MODE_W-1:0] m;
        unique case (s)
            ST_STBY:    m = MODE_STBY;
            ST_HIZ:     m = MODE_HIZ;
            ST_MUTE:    m = MODE_MUTE;
            ST_PLAY:    m = MODE_PLAY;
            ST_LL:      m = MODE_LL;
            ST_RAMP_UP: m = MODE_PLAY;
            ST_RAMP_DN: m = MODE_MUTE;
            default:    m = MODE_HIZ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/omc_pair_route.sv
module omc_pair_route #(
    parameter int NCH = 4,
    localparam int NPAIR = NCH / 2
) (
    input  logic [NCH-1:0]   mute_i,
    input  logic [NCH-1:0]   lowlow_i,
    input  logic [NCH-1:0]   fhiz_i,
    input  logic [NPAIR-1:0] pair_i,
    output logic [NCH-1:0]   mute_o,
    output logic [NCH-1:0]   lowlow_o,
    output logic [NCH-1:0]   fhiz_o,
    output logic [NCH-1:0]   follow_o
);

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam int LO = 2 * k;
        localparam int HI = 2 * k + 1;
        logic any_fault;

        always_comb begin
            any_fault = fhiz_i[LO] | fhiz_i[HI];
            if (pair_i[k]) begin
                mute_o[LO]   = mute_i[LO];
                mute_o[HI]   = mute_i[LO];
                lowlow_o[LO] = lowlow_i[LO];
                lowlow_o[HI] = lowlow_i[LO];
                fhiz_o[LO]   = any_fault;
                fhiz_o[HI]   = any_fault;
            end else begin
                mute_o[LO]   = mute_i[LO];
                mute_o[HI]   = mute_i[HI];
                lowlow_o[LO] = lowlow_i[LO];
                lowlow_o[HI] = lowlow_i[HI];
                fhiz_o[LO]   = fhiz_i[LO];
                fhiz_o[HI]   = fhiz_i[HI];
            end
            follow_o[LO] = 1'b0;
            follow_o[HI] = pair_i[k];
        end
    end

endmodule

// File: rtl/omc_chan_fsm.sv
module omc_chan_fsm
    import omc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_stby_i,
    input  logic              force_hiz_i,
    input  logic              reg_reset_i,
    input  logic              lowlow_i,
    input  logic              run_i,
    input  logic              mute_i,
    input  logic              ramp_done_i,
    input  logic              follow_en_i,
    input  omc_state_e        follow_d_i,
    output omc_state_e        state_d_o,
    output omc_state_e        state_q_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              st_hiz_o,
    output logic              st_ll_o,
    output logic              st_mute_o,
    output logic              st_play_o
);

    omc_state_e state_q, nxt, target;

    // Command resolution, highest precedence first
    always_comb begin
        if (force_stby_i)                     target = ST_STBY;
        else if (force_hiz_i || reg_reset_i)  target = ST_HIZ;
        else if (lowlow_i)                    target = ST_LL;
        else if (run_i)                       target = mute_i ? ST_MUTE : ST_PLAY;
        else                                  target = ST_HIZ;
    end

    always_comb begin
        unique case (state_q)
            ST_MUTE:    nxt = (target == ST_PLAY) ? ST_RAMP_UP : target;
            ST_PLAY:    nxt = (target == ST_MUTE) ? ST_RAMP_DN : target;
            ST_RAMP_UP: nxt = (target == ST_PLAY) ?
                              (ramp_done_i ? ST_PLAY : ST_RAMP_UP) : target;
            ST_RAMP_DN: nxt = (target == ST_MUTE) ?
                              (ramp_done_i ? ST_MUTE : ST_RAMP_DN) : target;
            ST_STBY, ST_HIZ, ST_LL: nxt = target;
            default:    nxt = ST_HIZ;
        endcase
        state_d_o = follow_en_i ? follow_d_i : nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HIZ;
        else        state_q <= state_d_o;
    end

    always_comb begin
        state_q_o = state_q;
        mode_o    = stage_code(state_q);
        st_hiz_o  = (state_q == ST_HIZ);
        st_ll_o   = (state_q == ST_LL);
        st_mute_o = (state_q == ST_MUTE) || (state_q == ST_RAMP_UP);
        st_play_o = (state_q == ST_PLAY) || (state_q == ST_RAMP_DN);
    end

    // R8: standby request wins on the next edge
    a_r8_standby_next: assert property (@(posedge clk) disable iff (!rst_n)
        force_stby_i |=> state_q == ST_STBY);

    // R7: Hi-Z request without standby gives Hi-Z on the next edge
    a_r7_fault_hiz_next: assert property (@(posedge clk) disable iff (!rst_n)
        (force_hiz_i && !force_stby_i) |=> state_q == ST_HIZ);

    // R3: a ramp toward play cannot settle without the strobe
    a_r3_ramp_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP_UP && !ramp_done_i && !follow_en_i) |=> state_q != ST_PLAY);

    // R3: play is never entered straight from mute by a channel that leads itself
    a_r3_no_skip_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state_q == ST_PLAY) && !$past(follow_en_i)) |-> $past(state_q) != ST_MUTE);

endmodule

// File: rtl/omc_mode_ctrl.sv
module omc_mode_ctrl
    import omc_pkg::*;
#(
    parameter int NCH = 4,
    localparam int NPAIR = NCH / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_reset_i,
    input  logic                hiz_to_play_i,
    input  logic [NCH-1:0]      mute_ctl_i,
    input  logic [NCH-1:0]      lowlow_ctl_i,
    input  logic [NPAIR-1:0]    pair_ctl_i,
    input  logic [NCH-1:0]      flt_hiz_i,
    input  logic                flt_stby_i,
    input  logic                ramp_done_i,
    output logic [3*NCH-1:0]    stage_mode_o,
    output logic [2*NCH-1:0]    stat_hiz_ll_o,
    output logic [2*NCH-1:0]    stat_mute_play_o
);

    logic [NCH-1:0] mute_r, ll_r, fhiz_r, follow;
    logic [NCH-1:0] s_hiz, s_ll, s_mute, s_play;
    omc_state_e     st_d [NCH];
    omc_state_e     st_q [NCH];

    omc_pair_route #(.NCH(NCH)) u_route (
        .mute_i   (mute_ctl_i),
        .lowlow_i (lowlow_ctl_i),
        .fhiz_i   (flt_hiz_i),
        .pair_i   (pair_ctl_i),
        .mute_o   (mute_r),
        .lowlow_o (ll_r),
        .fhiz_o   (fhiz_r),
        .follow_o (follow)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int LEAD = (c % 2 == 1) ? c - 1 : c;

        omc_chan_fsm u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .force_stby_i (flt_stby_i),
            .force_hiz_i  (fhiz_r[c]),
            .reg_reset_i  (reg_reset_i),
            .lowlow_i     (ll_r[c]),
            .run_i        (hiz_to_play_i),
            .mute_i       (mute_r[c]),
            .ramp_done_i  (ramp_done_i),
            .follow_en_i  (follow[c]),
            .follow_d_i   (st_d[LEAD]),
            .state_d_o    (st_d[c]),
            .state_q_o    (st_q[c]),
            .mode_o       (stage_mode_o[3*c +: 3]),
            .st_hiz_o     (s_hiz[c]),
            .st_ll_o      (s_ll[c]),
            .st_mute_o    (s_mute[c]),
            .st_play_o    (s_play[c])
        );

        // R8: a standby request steers every next state to standby
        a_r8_stby_all: assert property (@(posedge clk) disable iff (!rst_n)
            flt_stby_i |-> st_d[c] == ST_STBY);
    end

    assign stat_hiz_ll_o    = {s_ll, s_hiz};
    assign stat_mute_play_o = {s_mute, s_play};

    // R6: paired channels never differ once the pair bit has been sampled
    logic [NPAIR-1:0] pair_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_ctl_i;
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_chk
        a_r6_pair_lock: assert property (@(posedge clk) disable iff (!rst_n)
            pair_q[k] |-> st_q[2*k] == st_q[2*k+1]);
    end

endmodule

// File: tb/omc_mode_ctrl_tb.sv
module omc_mode_ctrl_tb;

    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_reset = 1'b0, run = 1'b0, stby = 1'b0, rdone = 1'b0;
    logic [NCH-1:0] mute = '0, ll = '0, fhiz = '0;
    logic [NCH/2-1:0] pair = '0;
    logic [3*NCH-1:0] mode;
    logic [2*NCH-1:0] shl, smp;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    omc_mode_ctrl #(.NCH(NCH)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_reset_i      (reg_reset),
        .hiz_to_play_i    (run),
        .mute_ctl_i       (mute),
        .lowlow_ctl_i     (ll),
        .pair_ctl_i       (pair),
        .flt_hiz_i        (fhiz),
        .flt_stby_i       (stby),
        .ramp_done_i      (rdone),
        .stage_mode_o     (mode),
        .stat_hiz_ll_o    (shl),
        .stat_mute_play_o (smp)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag, logic [11:0] m, logic [7:0] hl, logic [7:0] mp);
        check({tag, " mode"}, 32'(mode), 32'(m));
        check({tag, " hiz_ll"}, 32'(shl), 32'(hl));
        check({tag, " mute_play"}, 32'(smp), 32'(mp));
    endtask

    task automatic t_reset();
        check_all("R1 R5 reset", 12'h249, 8'h0F, 8'h00);
        mute = 4'b1010;
        tick();
        check_all("R2 run low keeps Hi-Z", 12'h249, 8'h0F, 8'h00);
    endtask

    task automatic t_run();
        run = 1'b1;
        mute = 4'b0101;
        tick();
        check_all("R2 R5 enter mute/play", 12'h69A, 8'h00, 8'h5A);
    endtask

    task automatic t_ramp();
        mute = 4'b1010;
        tick();
        check_all("R3 ramp started", 12'h4D3, 8'h00, 8'h5A);
        tick();
        check("R3 status held without strobe", 32'(smp), 32'h5A);
        rdone = 1'b1;
        tick();
        rdone = 1'b0;
        check_all("R3 ramp done", 12'h4D3, 8'h00, 8'hA5);
    endtask

    task automatic t_lowlow();
        ll = 4'b0001;
        tick();
        check_all("R4 low-low", 12'h4D4, 8'h10, 8'hA4);
        ll = 4'b0000;
        tick();
        check_all("R4 leave low-low", 12'h4D3, 8'h00, 8'hA5);
    endtask

    task automatic t_fault_hiz();
        fhiz = 4'b0100;
        tick();
        check_all("R7 fault Hi-Z", 12'h453, 8'h04, 8'hA1);
        mute = 4'b1110;
        tick();
        check("R7 commands blocked", 32'(mode), 32'h453);
        fhiz = 4'b0000;
        tick();
        check_all("R10 release", 12'h493, 8'h00, 8'hE1);
    endtask

    task automatic t_pair();
        pair = 2'b01;
        tick();
        check_all("R6 pair follow", 12'h49B, 8'h00, 8'hC3);
        ll = 4'b0010;
        tick();
        check("R6 upper bits ignored", 32'(mode), 32'h49B);
        fhiz = 4'b0010;
        tick();
        check_all("R7 pair fault both", 12'h489, 8'h03, 8'hC0);
        fhiz = '0;
        ll = '0;
        pair = '0;
        tick();
        check_all("R6 R10 unpair", 12'h493, 8'h00, 8'hE1);
    endtask

    task automatic t_collide();
        mute = 4'b1111;
        tick();
        check_all("R3 ramp down", 12'h492, 8'h00, 8'hE1);
        rdone = 1'b1;
        fhiz = 4'b0001;
        tick();
        check_all("R7 R10 fault beats ramp", 12'h491, 8'h01, 8'hE0);
        rdone = 1'b0;
        fhiz = '0;
        tick();
        check_all("R10 after cancelled ramp", 12'h492, 8'h00, 8'hF0);
    endtask

    task automatic t_regreset();
        reg_reset = 1'b1;
        tick();
        check_all("R9 reg reset", 12'h249, 8'h0F, 8'h00);
        tick();
        check("R9 held", 32'(mode), 32'h249);
        reg_reset = 1'b0;
        tick();
        check_all("R9 release", 12'h492, 8'h00, 8'hF0);
    endtask

    task automatic t_standby();
        stby = 1'b1;
        fhiz = 4'b0001;
        reg_reset = 1'b1;
        tick();
        check_all("R8 standby", 12'h000, 8'h00, 8'h00);
        stby = 1'b0;
        fhiz = '0;
        reg_reset = 1'b0;
        tick();
        check_all("R8 R10 leave standby", 12'h492, 8'h00, 8'hF0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #2 rst_n = 1'b1;
                #1;
                t_reset();
                t_run();
                t_ramp();
                t_lowlow();
                t_fault_hiz();
                t_pair();
                t_collide();
                t_regreset();
                t_standby();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule